// File: doc/BRIEF.md
# Byte/Word Configurable Flash Data Port

This block sits between the data pads of a parallel NOR-style memory and its internal 16-bit read and write datapaths. A mode input chooses between a 16-bit bus and an 8-bit bus. In the 16-bit mode every data pad carries data. In the 8-bit mode only the low eight pads carry data, and the top pad is turned into an input. That input supplies the least significant bit of a byte address, one position below the word address.

Output drivers turn on only for a genuine read cycle: chip enable low, output enable low and write enable high. In the 8-bit mode the block picks the correct half of the internal word for a read. For a write it steers the received byte onto the matching lane.

The mode input is not used directly. A registered copy follows it only while the device reports that it is idle. A change made during a busy operation therefore waits until the operation ends. The register resets to the 16-bit mode, which matches a pin that floats high.

Top module: `flash_dq_port`

## Requirements
- R1: After reset the latched mode is word mode (`byte_mode` = 0), whatever the level of `mode_pin` and `busy`.
- R2: In word mode, during a read cycle all 16 bits of `dq_oe` are 1 and `dq_o` equals `rd_word`.
- R3: In byte mode, during a read cycle `dq_o[7:0]` is `rd_word[7:0]` when `dq_i[15]` is 0 and `rd_word[15:8]` when `dq_i[15]` is 1.
- R4: In byte mode, `dq_oe[15:8]` is always 0, so pads 8 to 14 are high impedance and pad 15 is never driven. During a read cycle `dq_oe[7:0]` is all ones.
- R5: In byte mode `byte_addr` is `{word_addr, dq_i[15]}`. In word mode it is `{word_addr, 1'b0}`, and `dq_i[15]` has no effect on it.
- R6: A read cycle is `ce_n`=0, `oe_n`=0 and `we_n`=1. At any other time every bit of `dq_oe` is 0.
- R7: `mode_pin` (1 = word, 0 = byte) is copied into `byte_mode` on a rising clock edge only when `busy` is 0 at that edge. While `busy` is 1 the latched mode holds, and a pending change is applied at the first edge that sees `busy` at 0.
- R8: A write cycle is `ce_n`=0 and `we_n`=0. In a write cycle in word mode, `wr_lanes` is 2'b11 and `wr_data` equals `dq_i`. In byte mode, `wr_lanes` is 2'b01 when `dq_i[15]` is 0 and 2'b10 when it is 1, and `wr_data` carries `dq_i[7:0]` on both halves. Outside a write cycle `wr_lanes` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Bus width request, 1 = 16-bit, 0 = 8-bit |
| busy | input | 1 | High while an embedded operation runs |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| word_addr | input | ADDR_W | Word address from the address pads |
| rd_word | input | 16 | Word read from the array |
| dq_i | input | 16 | Pad input values |
| dq_o | output | 16 | Pad output values |
| dq_oe | output | 16 | Per-pad output enable |
| byte_addr | output | ADDR_W+1 | Byte address: word address plus low bit |
| wr_data | output | 16 | Write data steered to lanes |
| wr_lanes | output | 2 | Byte lanes written (bit 0 low, bit 1 high) |
| byte_mode | output | 1 | Latched mode, 1 = 8-bit |

## Verification
The bench changes `mode_pin` while `busy` is high and checks that the latched mode holds for several cycles. It then checks that the change lands exactly one edge after `busy` drops. A design that sampled the pin directly, or ignored `busy`, would switch width in the middle of an operation.

In byte mode the bench toggles pad 15 and checks the byte lane, the address low bit and the write lane mask. A swapped lane select returns the wrong half of the word, and a design that drives pad 15 would fight the external address.

In word mode the bench toggles pad 15 again and checks that the address low bit stays 0. Every combination of the three strobes is also tried. A design that keys its drivers on output enable alone would drive the bus during a write.

// File: rtl/flash_dq_pkg.sv
package flash_dq_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = DQ_W / 2;
    localparam int LANES  = DQ_W / BYTE_W;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_WORD = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic rd_cyc;
        logic wr_cyc;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_ctl(input logic ce_n,
                                            input logic oe_n,
                                            input logic we_n);
        bus_ctl_t c;
        c.rd_cyc = !ce_n && !oe_n && we_n;
        c.wr_cyc = !ce_n && !we_n;
        return c;
    endfunction

    function automatic logic [LANES-1:0] lane_onehot(input logic sel);
        logic [LANES-1:0] m;
        m = '0;
        m[sel] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/fdq_mode_latch.sv
module fdq_mode_latch
    import flash_dq_pkg::*;
#(
    parameter bus_mode_e RESET_MODE = MODE_WORD
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_pin,
    input  logic      busy,
    output bus_mode_e mode_q
);

    bus_mode_e mode_req;

    assign mode_req = mode_pin ? MODE_WORD : MODE_BYTE;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RESET_MODE;
        end else if (!busy && (mode_req != mode_q)) begin
            mode_q <= mode_req;
        end
    end

endmodule

// File: rtl/fdq_addr_ext.sv
module fdq_addr_ext
    import flash_dq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  bus_mode_e         mode,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              lsb_pad,
    output logic              lsb_eff,
    output logic [ADDR_W:0]   byte_addr
);

    always_comb begin
        lsb_eff   = (mode == MODE_BYTE) ? lsb_pad : 1'b0;
        byte_addr = {word_addr, lsb_eff};
    end

endmodule

// File: rtl/fdq_lane_path.sv
module fdq_lane_path
    import flash_dq_pkg::*;
(
    input  bus_mode_e        mode,
    input  bus_ctl_t         ctl,
    input  logic             lsb,
    input  logic [DQ_W-1:0]  rd_word,
    input  logic [DQ_W-1:0]  dq_i,
    output logic [DQ_W-1:0]  dq_o,
    output logic [DQ_W-1:0]  dq_oe,
    output logic [DQ_W-1:0]  wr_data,
    output logic [LANES-1:0] wr_lanes
);

    logic [BYTE_W-1:0] rd_lane [LANES];
    logic [BYTE_W-1:0] sel_byte;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign rd_lane[g] = rd_word[g*BYTE_W +: BYTE_W];
    end

    assign sel_byte = rd_lane[lsb];

    always_comb begin
        dq_o  = '0;
        dq_oe = '0;
        if (mode == MODE_WORD) begin
            dq_o = rd_word;
            if (ctl.rd_cyc) dq_oe = '1;
        end else begin
            dq_o[BYTE_W-1:0] = sel_byte;
            if (ctl.rd_cyc) dq_oe[BYTE_W-1:0] = '1;
        end
    end

    always_comb begin
        wr_lanes = '0;
        if (mode == MODE_WORD) begin
            wr_data = dq_i;
            if (ctl.wr_cyc) wr_lanes = '1;
        end else begin
            wr_data = {LANES{dq_i[BYTE_W-1:0]}};
            if (ctl.wr_cyc) wr_lanes = lane_onehot(lsb);
        end
    end

endmodule

// File: rtl/flash_dq_port.sv
module flash_dq_port
    import flash_dq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_pin,
    input  logic                        busy,
    input  logic                        ce_n,
    input  logic                        oe_n,
    input  logic                        we_n,
    input  logic [ADDR_W-1:0]           word_addr,
    input  logic [flash_dq_pkg::DQ_W-1:0]  rd_word,
    input  logic [flash_dq_pkg::DQ_W-1:0]  dq_i,
    output logic [flash_dq_pkg::DQ_W-1:0]  dq_o,
    output logic [flash_dq_pkg::DQ_W-1:0]  dq_oe,
    output logic [ADDR_W:0]             byte_addr,
    output logic [flash_dq_pkg::DQ_W-1:0]  wr_data,
    output logic [flash_dq_pkg::LANES-1:0] wr_lanes,
    output logic                        byte_mode
);

    bus_mode_e mode_q;
    bus_ctl_t  ctl;
    logic      lsb_eff;

    assign ctl       = decode_ctl(ce_n, oe_n, we_n);
    assign byte_mode = (mode_q == MODE_BYTE);

    fdq_mode_latch #(.RESET_MODE(MODE_WORD)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_pin (mode_pin),
        .busy     (busy),
        .mode_q   (mode_q)
    );

    fdq_addr_ext #(.ADDR_W(ADDR_W)) u_addr (
        .mode      (mode_q),
        .word_addr (word_addr),
        .lsb_pad   (dq_i[DQ_W-1]),
        .lsb_eff   (lsb_eff),
        .byte_addr (byte_addr)
    );

    fdq_lane_path u_lane (
        .mode     (mode_q),
        .ctl      (ctl),
        .lsb      (lsb_eff),
        .rd_word  (rd_word),
        .dq_i     (dq_i),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .wr_data  (wr_data),
        .wr_lanes (wr_lanes)
    );

endmodule

// File: rtl/flash_dq_port_chk.sv
module flash_dq_port_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_pin,
    input logic              busy,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [15:0]       dq_i,
    input logic [15:0]       dq_oe,
    input logic [ADDR_W:0]   byte_addr,
    input logic [1:0]        wr_lanes,
    input logic              byte_mode
);

    // R6: drivers are off outside a read cycle
    p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !(!ce_n && !oe_n && we_n) |-> dq_oe == 16'h0000);

    // R4: the upper pads are never driven in byte mode
    p_upper_hiz_r4: assert property (@(posedge clk) disable iff (rst)
        byte_mode |-> dq_oe[15:8] == 8'h00);

    // R2: a word-mode read drives every pad
    p_word_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (!byte_mode && !ce_n && !oe_n && we_n) |-> dq_oe == 16'hFFFF);

    // R5: the address low bit is zero in word mode
    p_word_lsb_r5: assert property (@(posedge clk) disable iff (rst)
        !byte_mode |-> byte_addr[0] == 1'b0);

    // R7: the latched mode holds while busy
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(byte_mode));

    // R7: the latched mode follows the pin when idle
    p_idle_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> byte_mode == !$past(mode_pin));

    // R8: a byte-mode write touches at most one lane
    p_byte_lane_r8: assert property (@(posedge clk) disable iff (rst)
        byte_mode |-> $countones(wr_lanes) <= 1);

endmodule

bind flash_dq_port flash_dq_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_pin  (mode_pin),
    .busy      (busy),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dq_i      (dq_i),
    .dq_oe     (dq_oe),
    .byte_addr (byte_addr),
    .wr_lanes  (wr_lanes),
    .byte_mode (byte_mode)
);

// File: tb/flash_dq_port_tb.sv
module flash_dq_port_tb;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_pin, busy, ce_n, oe_n, we_n;
    logic [AW-1:0] word_addr;
    logic [15:0]   rd_word, dq_i;
    logic [15:0]   dq_o, dq_oe, wr_data;
    logic [AW:0]   byte_addr;
    logic [1:0]    wr_lanes;
    logic          byte_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_dq_port #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .busy(busy),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .word_addr(word_addr),
        .rd_word(rd_word), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .byte_addr(byte_addr), .wr_data(wr_data), .wr_lanes(wr_lanes),
        .byte_mode(byte_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic set_mode(input logic word);
        @(negedge clk);
        busy = 1'b0; mode_pin = word;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; mode_pin = 1'b0; busy = 1'b1; idle_bus();
        word_addr = '0; rd_word = '0; dq_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset mode", 32'(byte_mode), 32'd0);
        check("R6 reset oe", 32'(dq_oe), 32'h0);
        mode_pin = 1'b1; busy = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_word_read();
        set_mode(1'b1);
        rd_word = 16'hA55A; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check("R2 word oe", 32'(dq_oe), 32'hFFFF);
        check("R2 word data", 32'(dq_o), 32'hA55A);
        rd_word = 16'h1234; #1;
        check("R2 word data 2", 32'(dq_o), 32'h1234);
        idle_bus();
    endtask

    task automatic t_gating();
        for (int k = 0; k < 8; k++) begin
            ce_n = k[0]; oe_n = k[1]; we_n = k[2];
            #1;
            if (k == 4) check("R6 read gate", 32'(dq_oe), 32'hFFFF);
            else        check("R6 no drive", 32'(dq_oe), 32'h0);
        end
        idle_bus();
    endtask

    task automatic t_byte_read();
        set_mode(1'b0);
        check("R7 to byte", 32'(byte_mode), 32'd1);
        rd_word = 16'hBEEF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        dq_i = 16'h0000; #1;
        check("R3 low byte", 32'(dq_o[7:0]), 32'hEF);
        check("R4 oe low", 32'(dq_oe), 32'h00FF);
        dq_i = 16'h8000; #1;
        check("R3 high byte", 32'(dq_o[7:0]), 32'hBE);
        check("R4 pad15 undriven", 32'(dq_oe[15:8]), 32'h0);
        idle_bus();
    endtask

    task automatic t_addr();
        word_addr = 20'hABCDE;
        dq_i = 16'h8000; #1;
        check("R5 byte lsb1", 32'(byte_addr), 32'h1579BD);
        dq_i = 16'h0000; #1;
        check("R5 byte lsb0", 32'(byte_addr), 32'h1579BC);
        set_mode(1'b1);
        dq_i = 16'h8000; #1;
        check("R5 word lsb ignored", 32'(byte_addr), 32'h1579BC);
    endtask

    task automatic t_write();
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        dq_i = 16'hC3A7; #1;
        check("R8 word lanes", 32'(wr_lanes), 32'h3);
        check("R8 word data", 32'(wr_data), 32'hC3A7);
        idle_bus();
        set_mode(1'b0);
        ce_n = 1'b0; we_n = 1'b0;
        dq_i = 16'h0042; #1;
        check("R8 byte lane0", 32'(wr_lanes), 32'h1);
        check("R8 byte data", 32'(wr_data), 32'h4242);
        dq_i = 16'h8042; #1;
        check("R8 byte lane1", 32'(wr_lanes), 32'h2);
        idle_bus(); #1;
        check("R8 no write", 32'(wr_lanes), 32'h0);
    endtask

    task automatic t_mode_defer();
        set_mode(1'b1);
        check("R7 word", 32'(byte_mode), 32'd0);
        @(negedge clk);
        busy = 1'b1; mode_pin = 1'b0;
        repeat (4) begin
            @(negedge clk); #1;
            check("R7 held while busy", 32'(byte_mode), 32'd0);
        end
        busy = 1'b0; #1;
        check("R7 not before edge", 32'(byte_mode), 32'd0);
        @(negedge clk); #1;
        check("R7 applied when idle", 32'(byte_mode), 32'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_word_read();
                t_gating();
                t_byte_read();
                t_addr();
                t_write();
                t_mode_defer();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule